// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the sampled levels of a parameterised GPIO port (32 pins by default) and decides, pin by pin, when an interrupt condition has occurred. Each pin carries a two-bit sensitivity code. The code selects one of four conditions: active-low level, active-high level, rising edge or falling edge. A separate per-pin bit replaces the code with "either edge". Pins that are driven as outputs are never examined. A detected condition sets a sticky status bit. The bit stays set until software clears it by writing a 1 to it.

The status vector is ANDed with an enable mask and reduced to interrupt lines. In single-line mode one line carries the OR of all masked bits. In split mode line 0 serves the lower half of the pins and line 1 serves the upper half. Register decoding lives elsewhere. The block receives the direction, sensitivity, any-edge and mask vectors directly, together with a clear strobe and its bit vector.

Level conditions are evaluated on every clock, so a level that is still present sets its status bit again right after any clear or configuration change. For one cycle after reset the block only captures pin levels, so a pin that is already high at reset release does not count as an edge.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the status vector is 0 and both interrupt lines are 0.
- R2: A pin whose pinIsOutput bit is 1 never sets its status bit, whatever its level and code.
- R3: In level mode the status bit is set on the clock edge at which the pin level matches the polarity. Code 2'b00 is active-low and code 2'b01 is active-high. Pin n's code is senseCfg[2n+1:2n], and bit 2n+1 = 0 means level mode.
- R4: In edge mode (senseCfg[2n+1] = 1) the status bit is set only on the edge at which the level differs from the previous sample. Code 2'b10 responds to a 0-to-1 change and code 2'b11 to a 1-to-0 change. The opposite change has no effect.
- R5: When anyEdgeCfg[n] is 1, every change of pin n sets its status bit. A steady level never sets it, whatever the code says.
- R6: Status bits are sticky. They stay set after the condition that set them goes away.
- R7: With clrStrobe high, each 1 in clrBits clears the matching status bit on the next edge. A 0 in clrBits leaves its bit unchanged.
- R8: If a pin's condition is detected in the same cycle as its clear, the bit remains set.
- R9: Interrupt lines are registered. Each line reflects status AND irqMask one clock after the status changes. In single-line mode irqOut[0] is the OR of all masked bits and irqOut[1] is 0.
- R10: With SPLIT_IRQ = 1, irqOut[0] is the OR of the masked bits of the lower half of the pins and irqOut[1] the OR of the masked bits of the upper half.
- R11: A masked status bit raises no interrupt. A mask change reaches the lines on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Sampled (already synchronised) pin levels |
| pinIsOutput | input | NUM_PINS | 1 = pin driven as output, excluded from detection |
| senseCfg | input | 2*NUM_PINS | Per-pin code: bit 2n+1 edge/level, bit 2n polarity |
| anyEdgeCfg | input | NUM_PINS | 1 = pin n reacts to both edges, overriding its code |
| irqMask | input | NUM_PINS | 1 = status bit may drive an interrupt line |
| clrStrobe | input | 1 | Qualifies clrBits for one cycle |
| clrBits | input | NUM_PINS | Write-one-to-clear pattern for the status bits |
| status | output | NUM_PINS | Sticky interrupt status |
| irqOut | output | 2 | Interrupt lines (line 1 used only when split) |

## Verification
The checker confirms on every cycle that output pins never gain a status bit and that status bits only fall where a qualified clear named them. It also confirms that each interrupt line equals the reduction of the previous cycle's masked status, for the selected split mode. Only the bench's scenarios show which condition each code actually responds to: level polarity, edge direction, and the any-edge override ignoring a steady level. They also show that a clear loses against a level still present, and that the clear pattern's zeros leave their bits alone.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Per-pin sensitivity code: MSB selects edge mode, LSB the polarity.
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_FALL = 2'b11
  } sense_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clrApply;   // clrBits qualified this cycle
    logic detectEn;   // detection armed (low for the priming cycle)
  } ctrl_strobes_t;

endpackage

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic       level,
  input  logic       prevLevel,
  input  logic       isOutput,
  input  logic [1:0] sense,
  input  logic       anyEdge,
  input  logic       detectEn,
  output logic       event_o
);

  logic changed;
  sense_e code;

  assign changed = level ^ prevLevel;
  assign code    = sense_e'(sense);

  always_comb begin
    event_o = 1'b0;
    if (detectEn && !isOutput) begin
      if (anyEdge) begin
        event_o = changed;
      end else begin
        unique case (code)
          SENSE_LOW:  event_o = !level;
          SENSE_HIGH: event_o = level;
          SENSE_RISE: event_o = changed && level;
          SENSE_FALL: event_o = changed && !level;
          default:    event_o = 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobes_t         strobes,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [NUM_PINS-1:0]   pinIsOutput,
  input  logic [2*NUM_PINS-1:0] senseCfg,
  input  logic [NUM_PINS-1:0]   anyEdgeCfg,
  input  logic [NUM_PINS-1:0]   clrBits,
  output logic [NUM_PINS-1:0]   status
);

  logic [NUM_PINS-1:0] prevLevel;
  logic [NUM_PINS-1:0] pinEvent;
  logic [NUM_PINS-1:0] clrVec;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_irq_pin u_pin (
      .level     (pinIn[i]),
      .prevLevel (prevLevel[i]),
      .isOutput  (pinIsOutput[i]),
      .sense     (senseCfg[2*i +: 2]),
      .anyEdge   (anyEdgeCfg[i]),
      .detectEn  (strobes.detectEn),
      .event_o   (pinEvent[i])
    );
  end

  assign clrVec = strobes.clrApply ? clrBits : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= '0;
      status    <= '0;
    end else begin
      prevLevel <= pinIn;
      status    <= (status & ~clrVec) | pinEvent;
    end
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS  = 32,
  parameter bit SPLIT_IRQ = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clrStrobe,
  input  logic [NUM_PINS-1:0] status,
  input  logic [NUM_PINS-1:0] irqMask,
  output ctrl_strobes_t       strobes,
  output logic [1:0]          irqOut
);

  localparam int HALF = NUM_PINS / 2;

  logic                primed;
  logic [NUM_PINS-1:0] masked;
  logic [1:0]          irqNext;

  assign masked = status & irqMask;

  if (SPLIT_IRQ) begin : g_split
    assign irqNext = {|masked[NUM_PINS-1:HALF], |masked[HALF-1:0]};
  end else begin : g_single
    assign irqNext = {1'b0, |masked};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed <= 1'b0;
      irqOut <= '0;
    end else begin
      primed <= 1'b1;
      irqOut <= irqNext;
    end
  end

  assign strobes.clrApply = clrStrobe;
  assign strobes.detectEn = primed;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS  = 32,
  parameter bit SPLIT_IRQ = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [NUM_PINS-1:0]   pinIsOutput,
  input  logic [2*NUM_PINS-1:0] senseCfg,
  input  logic [NUM_PINS-1:0]   anyEdgeCfg,
  input  logic [NUM_PINS-1:0]   irqMask,
  input  logic                  clrStrobe,
  input  logic [NUM_PINS-1:0]   clrBits,
  output logic [NUM_PINS-1:0]   status,
  output logic [1:0]            irqOut
);

  ctrl_strobes_t strobes;

  gpio_irq_ctrl #(
    .NUM_PINS  (NUM_PINS),
    .SPLIT_IRQ (SPLIT_IRQ)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clrStrobe (clrStrobe),
    .status    (status),
    .irqMask   (irqMask),
    .strobes   (strobes),
    .irqOut    (irqOut)
  );

  gpio_irq_dp #(
    .NUM_PINS (NUM_PINS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .pinIn       (pinIn),
    .pinIsOutput (pinIsOutput),
    .senseCfg    (senseCfg),
    .anyEdgeCfg  (anyEdgeCfg),
    .clrBits     (clrBits),
    .status      (status)
  );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NUM_PINS  = 32,
  parameter bit SPLIT_IRQ = 1'b0
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] pinIsOutput,
  input logic                clrStrobe,
  input logic [NUM_PINS-1:0] clrBits,
  input logic [NUM_PINS-1:0] irqMask,
  input logic [NUM_PINS-1:0] status,
  input logic [1:0]          irqOut
);

  localparam int HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0] maskedC;
  logic [NUM_PINS-1:0] clrEff;
  logic                lowAny;
  logic                highAny;
  logic                allAny;

  assign maskedC = status & irqMask;
  assign clrEff  = clrStrobe ? clrBits : '0;
  assign lowAny  = |maskedC[HALF-1:0];
  assign highAny = |maskedC[NUM_PINS-1:HALF];
  assign allAny  = |maskedC;

  // R2: an output pin never gains a status bit
  a_r2_output_no_set: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((status & ~$past(status) & $past(pinIsOutput)) == '0));

  // R6 / R7: a status bit falls only where a qualified clear named it
  a_r6_sticky_until_clear: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~status & $past(status) & ~$past(clrEff)) == '0));

  // R9 / R10: line 0 follows the previous cycle's masked status
  a_r9_line0_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut[0] == (SPLIT_IRQ ? $past(lowAny) : $past(allAny))));

  // R10 / R9: line 1 carries the upper half when split, else stays low
  a_r10_line1_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut[1] == (SPLIT_IRQ ? $past(highAny) : 1'b0)));

endmodule

bind gpio_irq_detect gpio_irq_chk #(
  .NUM_PINS  (NUM_PINS),
  .SPLIT_IRQ (SPLIT_IRQ)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .pinIsOutput (pinIsOutput),
  .clrStrobe   (clrStrobe),
  .clrBits     (clrBits),
  .irqMask     (irqMask),
  .status      (status),
  .irqOut      (irqOut)
);

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinIsOutput = '1;
  logic [2*NP-1:0] senseCfg = {NP{2'b01}};
  logic [NP-1:0] anyEdgeCfg = '0;
  logic [NP-1:0] irqMask = '0;
  logic          clrStrobe = 1'b0;
  logic [NP-1:0] clrBits = '0;
  logic [NP-1:0] status, statusSplit;
  logic [1:0]    irqOut, irqOutSplit;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(NP), .SPLIT_IRQ(1'b0)) dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinIsOutput(pinIsOutput),
    .senseCfg(senseCfg), .anyEdgeCfg(anyEdgeCfg), .irqMask(irqMask),
    .clrStrobe(clrStrobe), .clrBits(clrBits), .status(status), .irqOut(irqOut));

  gpio_irq_detect #(.NUM_PINS(NP), .SPLIT_IRQ(1'b1)) dutSplit (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinIsOutput(pinIsOutput),
    .senseCfg(senseCfg), .anyEdgeCfg(anyEdgeCfg), .irqMask(irqMask),
    .clrStrobe(clrStrobe), .clrBits(clrBits), .status(statusSplit),
    .irqOut(irqOutSplit));

  // Scoreboard items: kind 0 = status, 1 = single-line irq, 2 = split irq
  typedef struct {
    string       tag;
    int          kind;
    logic [31:0] exp;
  } item_t;

  item_t       sbQ[$];
  item_t       cur;
  logic [31:0] act;

  always @(negedge clk) begin
    while (sbQ.size() > 0) begin
      cur = sbQ.pop_front();
      case (cur.kind)
        0:       act = status;
        1:       act = {30'd0, irqOut};
        default: act = {30'd0, irqOutSplit};
      endcase
      checks++;
      if (act !== cur.exp) begin
        errors++;
        $display("FAIL %s kind %0d: actual %h expected %h",
                 cur.tag, cur.kind, act, cur.exp);
      end
    end
  end

  task automatic push(input string tag, input int kind, input logic [31:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    sbQ.push_back(it);
  endtask

  task automatic expStatus(input string tag, input logic [31:0] exp);
    push(tag, 0, exp);
  endtask

  task automatic expIrq(input string tag, input logic [1:0] single, input logic [1:0] split);
    push(tag, 1, {30'd0, single});
    push(tag, 2, {30'd0, split});
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic setCode(input int pin, input logic [1:0] code);
    senseCfg[2*pin +: 2] = code;
  endtask

  task automatic clearPulse(input logic [31:0] bits);
    clrStrobe = 1'b1;
    clrBits   = bits;
    step();
    clrStrobe = 1'b0;
    clrBits   = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    expStatus("R1 reset status", 32'h0);
    expIrq("R1 reset irq", 2'b00, 2'b00);
    step();

    // R2: all pins outputs, high level would match code 01
    pinIn = '1;
    step(); step();
    expStatus("R2 outputs ignored", 32'h0);
    pinIn = '0;

    // R3: active-high level, pin 31 stays an output (R2)
    pinIsOutput = 32'h8000_0000;
    step();
    expStatus("R3 no level yet", 32'h0);
    pinIn = 32'h8000_0001;
    step();
    expStatus("R3 high level sets, R2 pin31 ignored", 32'h1);

    // R6: condition removed, bit stays
    pinIn = 32'h8000_0000;
    step();
    expStatus("R6 sticky", 32'h1);

    // R7: clear and zeros in pattern
    clearPulse(32'h1);
    expStatus("R7 clear ones", 32'h0);
    pinIn = 32'h8000_0001;
    step();
    pinIn = 32'h8000_0000;
    expStatus("R3 high again", 32'h1);
    clearPulse(32'hFFFF_FFFE);
    expStatus("R7 zeros no effect", 32'h1);
    clearPulse(32'h1);
    expStatus("R7 clear again", 32'h0);

    // R3 active-low, R8 set wins over clear
    setCode(1, 2'b00);
    step();
    expStatus("R3 low level sets", 32'h2);
    clearPulse(32'h2);
    expStatus("R8 level present beats clear", 32'h2);
    setCode(1, 2'b01);
    clearPulse(32'h2);
    expStatus("R8 clear once condition gone", 32'h0);

    // R4 rising
    setCode(2, 2'b10);
    step();
    expStatus("R4 rise code idle", 32'h0);
    pinIn[2] = 1'b1;
    step();
    expStatus("R4 rising edge", 32'h4);
    clearPulse(32'h4);
    expStatus("R4 steady high no event", 32'h0);
    pinIn[2] = 1'b0;
    step();
    expStatus("R4 falling ignored by rise code", 32'h0);

    // R4 falling
    setCode(3, 2'b11);
    step();
    pinIn[3] = 1'b1;
    step();
    expStatus("R4 rising ignored by fall code", 32'h0);
    pinIn[3] = 1'b0;
    step();
    expStatus("R4 falling edge", 32'h8);
    clearPulse(32'h8);
    expStatus("R4 clear", 32'h0);

    // R5 any-edge overrides active-low code
    setCode(4, 2'b00);
    anyEdgeCfg[4] = 1'b1;
    step();
    expStatus("R5 steady low ignored", 32'h0);
    pinIn[4] = 1'b1;
    step();
    expStatus("R5 rising", 32'h10);
    clearPulse(32'h10);
    expStatus("R5 clear", 32'h0);
    pinIn[4] = 1'b0;
    step();
    expStatus("R5 falling", 32'h10);

    // R11 mask
    expIrq("R11 masked no irq", 2'b00, 2'b00);
    irqMask = 32'h0010_0010;
    step();
    expIrq("R11 mask enables next edge", 2'b01, 2'b01);

    // R9 registered delay
    clearPulse(32'h10);
    expStatus("R9 status cleared", 32'h0);
    expIrq("R9 irq lags one cycle", 2'b01, 2'b01);
    step();
    expIrq("R9 irq drops", 2'b00, 2'b00);

    // R10 upper half
    pinIn[20] = 1'b1;
    step();
    expStatus("R10 upper status", 32'h0010_0000);
    expIrq("R9 upper lag", 2'b00, 2'b00);
    step();
    expIrq("R10 split upper line", 2'b01, 2'b10);

    // R11 mask off
    irqMask = '0;
    step();
    expIrq("R11 mask off", 2'b00, 2'b00);
    expStatus("R6 status kept under mask", 32'h0010_0000);

    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule